// File: doc/BRIEF.md
# Fractional Baud Rate Generator

This block turns a reference clock enable into the sampling ticks a UART shifter needs. The reference rate is first divided by 1 or by 4. It is then divided by a 16-bit integer divisor that a 4-bit fraction stretches in steps of 1/16. The result is a one-cycle sample tick at 16, 8 or 4 times the serial bit rate. A second output, the bit tick, marks the sample tick that closes each serial bit time.

The fraction is spread over every run of 16 sample ticks. An accumulator adds the fraction once per sample tick. Each carry out of it lengthens the next sample period by one prescaled clock. Single periods are therefore the integer divisor or one more, while the mean is exact.

Settings are presented on plain inputs and captured on a load strobe. The load strobe also restarts every counter. A transmitter and a receiver each use their own instance, so the two directions can run at unrelated rates.

Top module: `frac_brg`

## Requirements
- R1: After reset the effective settings are integer divisor 1, fraction 0, 16X mode and prescale 1. While ref_en is held high, sample_tick is high on every cycle and bit_tick fires once every 16 cycles.
- R2: With pre4_sel captured as 1, only every fourth enabled reference cycle advances the divider. With pre4_sel captured as 0, every enabled reference cycle advances it.
- R3: The integer divisor is {div_hi, div_hi's low partner div_lo}, with div_hi as bits 15:8 and div_lo as bits 7:0. When the fraction is 0, every sample period is exactly that many prescaled clocks.
- R4: frac_mode[3:0] is a fraction F in sixteenths. Every sample period is D or D+1 prescaled clocks, and any 16 consecutive sample periods total exactly 16·D+F prescaled clocks.
- R5: frac_mode[5:4] picks the oversampling ratio: 00 gives 16, 01 gives 8 and 10 gives 4. bit_tick is high only together with sample_tick, on every ratio-th sample tick.
- R6: Each bit period is within one prescaled clock of (D+F/16)·ratio·prescale reference cycles. Any 8 consecutive bit periods (a multiple of 16 sample ticks in every mode) total that ideal exactly.
- R7: A high load captures div_lo, div_hi, frac_mode and pre4_sel and restarts the prescaler, divider, fraction accumulator and bit counter. Both outputs are low in the cycle after the load. With fraction 0, the first bit_tick rises after exactly D·ratio·prescale enabled reference cycles.
- R8: An integer divisor of 0 behaves as 1, and mode code 11 behaves as 16X.
- R9: No tick is produced in a cycle that follows a cycle with ref_en low. Periods count enabled reference cycles only.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_en | input | 1 | Reference clock enable, one pulse per reference cycle |
| div_lo | input | 8 | Integer divisor bits 7:0 |
| div_hi | input | 8 | Integer divisor bits 15:8 |
| frac_mode | input | 8 | Bits 3:0 fraction in sixteenths, bits 5:4 oversampling code, bits 7:6 unused |
| pre4_sel | input | 1 | 1 selects divide-by-4 prescaling, 0 selects divide-by-1 |
| load | input | 1 | Capture the settings and restart all counters |
| sample_tick | output | 1 | One-cycle pulse per sampling period |
| bit_tick | output | 1 | One-cycle pulse on the sample tick that ends a bit time |

## Verification
A fraction accumulator in the wrong phase or with a dropped carry does not disturb any single period beyond one clock. It does show up as a wrong total over the first 16 sample ticks after a load, so the bench compares exact eight-bit sums as well as per-bit bounds. A miscounting bit counter or a prescaler in the wrong phase shifts the first bit tick after a load. That shift is visible within one bit time as a wrong cycle count. A setting that is captured but not cleared, or a restart that is ignored, shows immediately as a tick in the cycle after load or as a mismatched first-bit latency.

// File: rtl/frac_brg_pkg.sv
package frac_brg_pkg;

    localparam int BYTE_W   = 8;
    localparam int DIV_W    = 2 * BYTE_W;
    localparam int FRAC_W   = 4;
    localparam int PRE_DIV  = 4;
    localparam int OSC_W    = 5;

    typedef enum logic [1:0] {
        OS_X16 = 2'b00,
        OS_X8  = 2'b01,
        OS_X4  = 2'b10,
        OS_RSV = 2'b11
    } os_mode_e;

    typedef struct packed {
        logic [DIV_W-1:0]  idiv;
        logic [FRAC_W-1:0] frac;
        os_mode_e          mode;
        logic              pre4;
    } brg_cfg_t;

    localparam brg_cfg_t CFG_RESET = '{
        idiv: DIV_W'(1),
        frac: '0,
        mode: OS_X16,
        pre4: 1'b0
    };

    function automatic logic [DIV_W-1:0] eff_div(input logic [DIV_W-1:0] d);
        return (d == '0) ? DIV_W'(1) : d;
    endfunction

    function automatic logic [OSC_W-1:0] os_len(input os_mode_e m);
        case (m)
            OS_X8:   return OSC_W'(8);
            OS_X4:   return OSC_W'(4);
            default: return OSC_W'(16);
        endcase
    endfunction

endpackage

// File: rtl/brg_prescaler.sv
module brg_prescaler #(
    parameter int RATIO = frac_brg_pkg::PRE_DIV,
    localparam int CW   = (RATIO > 1) ? $clog2(RATIO) : 1
) (
    input  logic clk,
    input  logic rst,
    input  logic restart,
    input  logic ref_en,
    input  logic pre_sel,
    output logic pre_tick
);
    logic [CW-1:0] cnt;
    logic          wrap;

    assign wrap     = (cnt == CW'(RATIO - 1));
    assign pre_tick = ref_en && (!pre_sel || wrap);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (ref_en && pre_sel) begin
            cnt <= wrap ? '0 : cnt + CW'(1);
        end
    end
endmodule

// File: rtl/brg_divider.sv
module brg_divider
    import frac_brg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              restart,
    input  logic              pre_tick,
    input  logic [DIV_W-1:0]  idiv,
    input  logic [FRAC_W-1:0] frac,
    output logic              smp_tick
);
    logic [DIV_W:0]    cnt;
    logic [DIV_W:0]    plen;
    logic [DIV_W:0]    last;
    logic [FRAC_W-1:0] acc;
    logic [FRAC_W:0]   sum;
    logic              extra;

    always_comb begin
        plen     = {1'b0, eff_div(idiv)} + {{DIV_W{1'b0}}, extra};
        last     = plen - (DIV_W+1)'(1);
        sum      = {1'b0, acc} + {1'b0, frac};
        smp_tick = pre_tick && (cnt == last);
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt   <= '0;
            acc   <= '0;
            extra <= 1'b0;
        end else if (pre_tick) begin
            if (cnt == last) begin
                cnt   <= '0;
                acc   <= sum[FRAC_W-1:0];
                extra <= sum[FRAC_W];
            end else begin
                cnt <= cnt + (DIV_W+1)'(1);
            end
        end
    end
endmodule

// File: rtl/brg_bitcount.sv
module brg_bitcount
    import frac_brg_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     restart,
    input  logic     smp_tick,
    input  os_mode_e mode,
    output logic     bit_end
);
    logic [OSC_W-1:0] cnt;
    logic [OSC_W-1:0] last;

    assign last    = os_len(mode) - OSC_W'(1);
    assign bit_end = smp_tick && (cnt == last);

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            cnt <= '0;
        end else if (smp_tick) begin
            cnt <= bit_end ? '0 : cnt + OSC_W'(1);
        end
    end
endmodule

// File: rtl/frac_brg.sv
module frac_brg
    import frac_brg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ref_en,
    input  logic [BYTE_W-1:0] div_lo,
    input  logic [BYTE_W-1:0] div_hi,
    input  logic [BYTE_W-1:0] frac_mode,
    input  logic              pre4_sel,
    input  logic              load,
    output logic              sample_tick,
    output logic              bit_tick
);
    brg_cfg_t cfg;
    logic     pre_tick;
    logic     smp_raw;
    logic     bit_raw;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (load) begin
            cfg.idiv <= {div_hi, div_lo};
            cfg.frac <= frac_mode[FRAC_W-1:0];
            cfg.mode <= os_mode_e'(frac_mode[FRAC_W+1:FRAC_W]);
            cfg.pre4 <= pre4_sel;
        end
    end

    brg_prescaler #(.RATIO(PRE_DIV)) u_pre (
        .clk      (clk),
        .rst      (rst),
        .restart  (load),
        .ref_en   (ref_en),
        .pre_sel  (cfg.pre4),
        .pre_tick (pre_tick)
    );

    brg_divider u_div (
        .clk      (clk),
        .rst      (rst),
        .restart  (load),
        .pre_tick (pre_tick),
        .idiv     (cfg.idiv),
        .frac     (cfg.frac),
        .smp_tick (smp_raw)
    );

    brg_bitcount u_bit (
        .clk      (clk),
        .rst      (rst),
        .restart  (load),
        .smp_tick (smp_raw),
        .mode     (cfg.mode),
        .bit_end  (bit_raw)
    );

    always_ff @(posedge clk) begin
        if (rst || load) begin
            sample_tick <= 1'b0;
            bit_tick    <= 1'b0;
        end else begin
            sample_tick <= smp_raw;
            bit_tick    <= bit_raw;
        end
    end
endmodule

// File: rtl/frac_brg_chk.sv
module frac_brg_chk
    import frac_brg_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ref_en,
    input logic [BYTE_W-1:0] frac_mode,
    input logic              pre4_sel,
    input logic              load,
    input logic              sample_tick,
    input logic              bit_tick
);
    logic [OSC_W-1:0] os_q;
    logic             pre4_q;
    logic [OSC_W-1:0] smp_since;

    always_ff @(posedge clk) begin
        if (rst) begin
            os_q   <= OSC_W'(16);
            pre4_q <= 1'b0;
        end else if (load) begin
            pre4_q <= pre4_sel;
            case (frac_mode[5:4])
                2'b01:   os_q <= OSC_W'(8);
                2'b10:   os_q <= OSC_W'(4);
                default: os_q <= OSC_W'(16);
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            smp_since <= '0;
        end else if (sample_tick) begin
            smp_since <= bit_tick ? '0 : smp_since + OSC_W'(1);
        end
    end

    // R5
    bit_in_sample_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> sample_tick);

    // R5
    bit_spacing_chk: assert property (@(posedge clk) disable iff (rst)
        bit_tick |-> (smp_since == os_q - OSC_W'(1)));

    // R7
    load_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        load |=> (!sample_tick && !bit_tick));

    // R9
    no_ref_no_tick_chk: assert property (@(posedge clk) disable iff (rst)
        !ref_en |=> !sample_tick);

    // R2
    pre4_gap_chk: assert property (@(posedge clk) disable iff (rst)
        (pre4_q && sample_tick && !load) |=> !sample_tick);
endmodule

bind frac_brg frac_brg_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .ref_en      (ref_en),
    .frac_mode   (frac_mode),
    .pre4_sel    (pre4_sel),
    .load        (load),
    .sample_tick (sample_tick),
    .bit_tick    (bit_tick)
);

// File: tb/frac_brg_test.sv
module frac_brg_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       ref_en = 1'b1;
    logic [7:0] div_lo = 8'd1;
    logic [7:0] div_hi = 8'd0;
    logic [7:0] frac_mode = 8'd0;
    logic       pre4_sel = 1'b0;
    logic       load = 1'b0;
    logic       sample_tick;
    logic       bit_tick;
    logic       ref_half = 1'b0;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    typedef struct {
        int    ideal16;
        int    tol16;
        int    os;
        bit    last;
        int    ngrp;
        string tag;
    } item_t;

    item_t q[$];

    frac_brg uut (
        .clk         (clk),
        .rst         (rst),
        .ref_en      (ref_en),
        .div_lo      (div_lo),
        .div_hi      (div_hi),
        .frac_mode   (frac_mode),
        .pre4_sel    (pre4_sel),
        .load        (load),
        .sample_tick (sample_tick),
        .bit_tick    (bit_tick)
    );

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    initial begin
        forever begin
            @(negedge clk);
            ref_en = ref_half ? ~ref_en : 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: measures each bit period and compares against the queue.
    initial begin
        int last_bit = 0;
        int smp_cnt = 0;
        int sum = 0;
        forever begin
            @(negedge clk);
            if (sample_tick) smp_cnt++;
            if (bit_tick) begin
                if (q.size() > 0) begin
                    item_t it;
                    int per;
                    int diff;
                    it = q.pop_front();
                    per = cyc - last_bit;
                    diff = per * 16 - it.ideal16;
                    if (diff < 0) diff = -diff;
                    chk(diff < it.tol16, {it.tag, " R6 bit period"}, per * 16, it.ideal16);
                    chk(smp_cnt == it.os, {it.tag, " R5 samples per bit"}, smp_cnt, it.os);
                    sum += per;
                    if (it.last) begin
                        chk(sum * 16 == it.ideal16 * it.ngrp, {it.tag, " R6 group total"},
                            sum * 16, it.ideal16 * it.ngrp);
                        sum = 0;
                    end
                end else begin
                    sum = 0;
                end
                last_bit = cyc;
                smp_cnt = 0;
            end
        end
    end

    // Driver: waits for a bit boundary and queues the expected periods.
    task automatic push_group(input int ideal16, input int tol16, input int os, input string tag);
        localparam int NGRP = 8;
        do @(negedge clk); while (!bit_tick);
        @(negedge clk);
        for (int i = 0; i < NGRP; i++) begin
            item_t it;
            it.ideal16 = ideal16;
            it.tol16   = tol16;
            it.os      = os;
            it.last    = (i == NGRP - 1);
            it.ngrp    = NGRP;
            it.tag     = tag;
            q.push_back(it);
        end
        while (q.size() > 0) @(negedge clk);
    endtask

    task automatic do_load(input int d, input int fm, input bit p4);
        @(negedge clk);
        div_lo    = d[7:0];
        div_hi    = d[15:8];
        frac_mode = fm[7:0];
        pre4_sel  = p4;
        load      = 1'b1;
        @(negedge clk);
        load      = 1'b0;
    endtask

    task automatic run_cfg(input int d, input int fm, input bit p4, input bit half,
                           input string tag);
        int de;
        int f;
        int os;
        int p;
        int ce;
        ref_half = half;
        do_load(d, fm, p4);
        de = (d == 0) ? 1 : d;
        f  = fm & 15;
        case ((fm >> 4) & 3)
            1:       os = 8;
            2:       os = 4;
            default: os = 16;
        endcase
        p  = p4 ? 4 : 1;
        ce = half ? 2 : 1;
        push_group((de * 16 + f) * os * p * ce, 16 * p * ce, os, tag);
        ref_half = 1'b0;
    endtask

    // R7: latency from load to the first bit tick.
    task automatic restart_chk(input int d, input int fm, input bit p4, input int exp);
        int n = 0;
        do_load(d, fm, p4);
        chk(!sample_tick && !bit_tick, "R7 outputs low after load",
            {sample_tick, bit_tick}, 0);
        do begin
            @(negedge clk);
            n++;
        end while (!bit_tick && n < 100000);
        chk(n == exp, "R7 first bit latency", n, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(!sample_tick && !bit_tick, "R1 outputs low in reset", {sample_tick, bit_tick}, 0);
        rst = 1'b0;
        for (int i = 0; i < 5; i++) begin
            @(negedge clk);
            chk(sample_tick == 1'b1, "R1 sample every cycle after reset", sample_tick, 1);
        end
        push_group(16 * 16, 16, 16, "R1 reset default");

        // R4: individual sample periods with divisor 39 + 1/16
        do_load(39, 8'h01, 1'b0);
        begin
            int prev = 0;
            int total = 0;
            do @(negedge clk); while (!sample_tick);
            prev = cyc;
            for (int i = 0; i < 16; i++) begin
                int per;
                do @(negedge clk); while (!sample_tick);
                per = cyc - prev;
                prev = cyc;
                total += per;
                chk(per == 39 || per == 40, "R4 single sample period", per, 39);
            end
            chk(total == 625, "R4 sixteen sample total", total, 625);
        end

        run_cfg(39, 8'h01, 1'b0, 1'b0, "R4 16X d39 f1");
        run_cfg(5, 8'h17, 1'b0, 1'b0, "R5 8X d5 f7");
        run_cfg(3, 8'h20, 1'b1, 1'b0, "R2 4X d3 pre4");
        run_cfg(258, 8'h20, 1'b0, 1'b0, "R3 high byte d258");
        run_cfg(0, 8'h30, 1'b0, 1'b0, "R8 zero div mode11");
        run_cfg(2, 8'h2F, 1'b1, 1'b1, "R9 half rate ref");
        restart_chk(3, 8'h20, 1'b1, 48);
        restart_chk(2, 8'h00, 1'b0, 32);
        restart_chk(0, 8'h30, 1'b0, 16);

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule